// File: doc/BRIEF.md
# Dual-Counter PWM Timer

This block holds two independent count channels, each with a control word, a load value and a live count. A channel counts up or down from its load value, marks the end of its span, and then reloads or stops. Both channels can be started together by one control write. When both control words hold a particular combination of bits, the pair acts as a single pulse-width modulator. Channel 0 sets the period and channel 1 sets the high time, and the result drives one output pin.

Software reaches the block through a plain 32-bit register port with an address, a write strobe, write data and combinational read data. The count width is a parameter. A running modulator takes new load values only at the end of the period in progress, so reprogramming never produces a broken pulse. A high time equal to the period gives a flat low output.

Top module: `pwm_dual_timer`

## Requirements
- R1: Byte offsets 0x00, 0x04, 0x08 address control, load and count of channel 0, and 0x0C, 0x10, 0x14 the same for channel 1. Other addresses read as zero. Writes to count registers are ignored. Load registers keep and return only the low CNT_W bits. Control bits: 0 capture-select, 1 count-down, 2 output-enable, 4 auto-reload, 5 load, 7 enable, 9 PWM, 10 start-both, 11 chain. All other control bits read as zero.
- R2: While a channel's load bit is set, its count equals its load register one cycle later, and the channel does not count.
- R3: An enabled channel with load clear steps by one per cycle. Down-counting goes to 0 and up-counting goes to the all-ones value. It holds that value for one more cycle and then reloads if auto-reload is set. Otherwise it stops and clears its enable bit. A down span is L+2 cycles and an up span is max−L+2 cycles.
- R4: Writing 1 to bit 10 of either control word sets the enable bit of both channels at the same edge. Bit 10 always reads as zero.
- R5: The output is high only while both control words have capture-select, load and chain (chain is checked in channel 0 only) clear, and output-enable, PWM, enable and auto-reload set. Otherwise the output is low.
- R6: With a high span D smaller than the period span P, the output is high for D cycles and low for P−D cycles. The first period starts in the cycle after the enabling write.
- R7: When D equals P, the output stays low throughout.
- R8: When D exceeds P, the output stays high throughout.
- R9: Load writes during a running period leave that period unchanged. The new spans apply from the next period.
- R10: The count-down bit of each channel stays as written and sets that channel's span in PWM operation.
- R11: After reset, all registers read zero and the output is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_addr | input | ADDR_W | Byte address of the register access |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr (combinational) |
| pwm_out | output | 1 | Modulated output |

## Verification
The hardest case to reach from the ports is a load change that lands in the middle of a running period. It has to be written while the old period's counters are partway through, and the output must keep the old shape until the wrap. The bench runs the register writes in one thread and an independent cycle-by-cycle comparison of the output in another. The writes are timed to fall a few cycles into a long period. Beyond that case, every pair of load values is swept in both directions at a 4-bit count width. This covers the equal-span case and the case where the high span exceeds the period.

// File: rtl/pwmt_pkg.sv
package pwmt_pkg;

    localparam int CB_CAPT  = 0;
    localparam int CB_DOWN  = 1;
    localparam int CB_GENO  = 2;
    localparam int CB_ARLD  = 4;
    localparam int CB_LOAD  = 5;
    localparam int CB_ENA   = 7;
    localparam int CB_PWM   = 9;
    localparam int CB_ENALL = 10;
    localparam int CB_CASC  = 11;

    localparam int NUM_REGS = 6;

    typedef enum logic [2:0] {
        RI_CTRL0 = 3'd0,
        RI_LOAD0 = 3'd1,
        RI_CNT0  = 3'd2,
        RI_CTRL1 = 3'd3,
        RI_LOAD1 = 3'd4,
        RI_CNT1  = 3'd5
    } reg_idx_e;

    typedef struct packed {
        logic casc;
        logic pwm;
        logic ena;
        logic load;
        logic arld;
        logic geno;
        logic down;
        logic capt;
    } ctrl_t;

    function automatic ctrl_t ctrl_from_word(input logic [31:0] w);
        ctrl_t c;
        c.capt = w[CB_CAPT];
        c.down = w[CB_DOWN];
        c.geno = w[CB_GENO];
        c.arld = w[CB_ARLD];
        c.load = w[CB_LOAD];
        c.ena  = w[CB_ENA];
        c.pwm  = w[CB_PWM];
        c.casc = w[CB_CASC];
        return c;
    endfunction

    function automatic logic [31:0] ctrl_to_word(input ctrl_t c);
        logic [31:0] w;
        w = '0;
        w[CB_CAPT] = c.capt;
        w[CB_DOWN] = c.down;
        w[CB_GENO] = c.geno;
        w[CB_ARLD] = c.arld;
        w[CB_LOAD] = c.load;
        w[CB_ENA]  = c.ena;
        w[CB_PWM]  = c.pwm;
        w[CB_CASC] = c.casc;
        return w;
    endfunction

    // Channel is configured for waveform generation (chain checked separately).
    function automatic logic ctrl_pwm_ready(input ctrl_t c);
        return ~c.capt & c.pwm & c.geno & c.ena & c.arld & ~c.load;
    endfunction

endpackage

// File: rtl/pwmt_counter.sv
module pwmt_counter
    import pwmt_pkg::*;
#(
    parameter int CNT_W   = 16,
    parameter bit IS_DUTY = 1'b0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ctrl_we,
    input  ctrl_t            wr_ctrl,
    input  logic             load_we,
    input  logic [CNT_W-1:0] wr_load,
    input  logic             ena_all,
    input  logic             pwm_mode,
    input  logic             restart,
    output ctrl_t            ctrl_o,
    output logic [CNT_W-1:0] load_o,
    output logic [CNT_W-1:0] cnt_o,
    output logic             wrap_evt,
    output logic             reload_evt
);

    typedef struct packed {
        ctrl_t            ctrl;
        logic [CNT_W-1:0] load;
        logic [CNT_W-1:0] cnt;
        logic             wrap;
        logic             done;
    } chan_t;

    chan_t s_d, s_q;
    logic  running;
    logic  at_term;
    logic  duty_role;

    assign duty_role = IS_DUTY & pwm_mode;

    always_comb begin
        s_d     = s_q;
        running = s_q.ctrl.ena & ~s_q.ctrl.load;
        at_term = s_q.ctrl.down ? (s_q.cnt == '0) : (s_q.cnt == '1);

        if (!pwm_mode) begin
            s_d.done = 1'b0;
        end

        if (s_q.ctrl.load) begin
            s_d.cnt  = s_q.load;
            s_d.wrap = 1'b0;
            s_d.done = 1'b0;
        end else if (running) begin
            if (s_q.wrap) begin
                s_d.wrap = 1'b0;
                if (duty_role) begin
                    s_d.done = 1'b1;
                end else if (s_q.ctrl.arld) begin
                    s_d.cnt = s_q.load;
                end else begin
                    s_d.ctrl.ena = 1'b0;
                end
            end else if (!(s_q.done && pwm_mode)) begin
                if (at_term) begin
                    s_d.wrap = 1'b1;
                end else if (s_q.ctrl.down) begin
                    s_d.cnt = s_q.cnt - 1'b1;
                end else begin
                    s_d.cnt = s_q.cnt + 1'b1;
                end
            end
        end

        // Duty channel restarts with the period channel.
        if (restart) begin
            s_d.cnt  = s_q.load;
            s_d.wrap = 1'b0;
            s_d.done = 1'b0;
        end

        if (ctrl_we) begin
            s_d.ctrl = wr_ctrl;
        end
        if (ena_all) begin
            s_d.ctrl.ena = 1'b1;
        end
        if (load_we) begin
            s_d.load = wr_load;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign ctrl_o     = s_q.ctrl;
    assign load_o     = s_q.load;
    assign cnt_o      = s_q.cnt;
    assign wrap_evt   = s_q.ctrl.ena & ~s_q.ctrl.load & s_q.wrap;
    assign reload_evt = wrap_evt & s_q.ctrl.arld & ~duty_role;

endmodule

// File: rtl/pwmt_pwm_gen.sv
module pwmt_pwm_gen
    import pwmt_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  ctrl_t            ctrl0,
    input  ctrl_t            ctrl1,
    input  logic [CNT_W-1:0] load0,
    input  logic [CNT_W-1:0] load1,
    input  logic             period_wrap,
    input  logic             duty_wrap,
    output logic             pwm_mode,
    output logic             pwm_out
);

    localparam int SPAN_W = CNT_W + 2;
    localparam logic [SPAN_W-1:0] MAXV = {2'b00, {CNT_W{1'b1}}};

    typedef struct packed {
        logic hi;
    } gen_t;

    gen_t s_d, s_q;
    logic [SPAN_W-1:0] span0, span1;
    logic unused_casc1;

    function automatic logic [SPAN_W-1:0] span_of(input logic dn, input logic [CNT_W-1:0] l);
        logic [SPAN_W-1:0] lv;
        lv = {2'b00, l};
        return dn ? (lv + SPAN_W'(2)) : (MAXV - lv + SPAN_W'(2));
    endfunction

    assign unused_casc1 = ctrl1.casc;

    assign pwm_mode = ctrl_pwm_ready(ctrl0) & ctrl_pwm_ready(ctrl1) & ~ctrl0.casc;
    assign span0    = span_of(ctrl0.down, load0);
    assign span1    = span_of(ctrl1.down, load1);

    always_comb begin
        s_d = s_q;
        if (!pwm_mode) begin
            // Preset for the first period; equal spans start low.
            s_d.hi = (span0 != span1);
        end else if (duty_wrap) begin
            s_d.hi = 1'b0;
        end else if (period_wrap) begin
            s_d.hi = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign pwm_out = pwm_mode & s_q.hi;

endmodule

// File: rtl/pwm_dual_timer.sv
module pwm_dual_timer
    import pwmt_pkg::*;
#(
    parameter int CNT_W  = 16,
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic              reg_wr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    output logic              pwm_out
);

    localparam int IDX_W = ADDR_W - 2;
    localparam int NCH   = 2;

    ctrl_t            ch_ctrl   [NCH];
    logic [CNT_W-1:0] ch_load   [NCH];
    logic [CNT_W-1:0] ch_cnt    [NCH];
    logic             ch_wrap   [NCH];
    logic             ch_reload [NCH];
    logic             ch_restart[NCH];
    logic             ch_ctrl_we[NCH];
    logic             ch_load_we[NCH];

    logic             aligned;
    logic [IDX_W-1:0] widx;
    logic             ena_all;
    logic             pwm_mode;
    ctrl_t            wr_ctrl;
    logic             unused_sink;

    assign aligned = (reg_addr[1:0] == 2'b00);
    assign widx    = reg_addr[ADDR_W-1:2];
    assign wr_ctrl = ctrl_from_word(reg_wdata);

    function automatic logic hit(input logic [IDX_W-1:0] w, input reg_idx_e r);
        return w == IDX_W'(r);
    endfunction

    assign ena_all = reg_wr & aligned & reg_wdata[CB_ENALL]
                   & (hit(widx, RI_CTRL0) | hit(widx, RI_CTRL1));

    assign ch_ctrl_we[0] = reg_wr & aligned & hit(widx, RI_CTRL0);
    assign ch_ctrl_we[1] = reg_wr & aligned & hit(widx, RI_CTRL1);
    assign ch_load_we[0] = reg_wr & aligned & hit(widx, RI_LOAD0);
    assign ch_load_we[1] = reg_wr & aligned & hit(widx, RI_LOAD1);

    generate
        for (genvar g = 0; g < NCH; g++) begin : g_ch
            if (g == 0) begin : g_period
                assign ch_restart[g] = 1'b0;
            end else begin : g_duty
                assign ch_restart[g] = ch_reload[0] & pwm_mode;
            end

            pwmt_counter #(
                .CNT_W  (CNT_W),
                .IS_DUTY(g == 1)
            ) u_cnt (
                .clk       (clk),
                .rst_n     (rst_n),
                .ctrl_we   (ch_ctrl_we[g]),
                .wr_ctrl   (wr_ctrl),
                .load_we   (ch_load_we[g]),
                .wr_load   (reg_wdata[CNT_W-1:0]),
                .ena_all   (ena_all),
                .pwm_mode  (pwm_mode),
                .restart   (ch_restart[g]),
                .ctrl_o    (ch_ctrl[g]),
                .load_o    (ch_load[g]),
                .cnt_o     (ch_cnt[g]),
                .wrap_evt  (ch_wrap[g]),
                .reload_evt(ch_reload[g])
            );
        end
    endgenerate

    pwmt_pwm_gen #(
        .CNT_W(CNT_W)
    ) u_gen (
        .clk        (clk),
        .rst_n      (rst_n),
        .ctrl0      (ch_ctrl[0]),
        .ctrl1      (ch_ctrl[1]),
        .load0      (ch_load[0]),
        .load1      (ch_load[1]),
        .period_wrap(ch_wrap[0]),
        .duty_wrap  (ch_wrap[1]),
        .pwm_mode   (pwm_mode),
        .pwm_out    (pwm_out)
    );

    always_comb begin
        reg_rdata = '0;
        if (aligned) begin
            if (hit(widx, RI_CTRL0)) reg_rdata = ctrl_to_word(ch_ctrl[0]);
            if (hit(widx, RI_LOAD0)) reg_rdata = 32'(ch_load[0]);
            if (hit(widx, RI_CNT0))  reg_rdata = 32'(ch_cnt[0]);
            if (hit(widx, RI_CTRL1)) reg_rdata = ctrl_to_word(ch_ctrl[1]);
            if (hit(widx, RI_LOAD1)) reg_rdata = 32'(ch_load[1]);
            if (hit(widx, RI_CNT1))  reg_rdata = 32'(ch_cnt[1]);
        end
    end

    assign unused_sink = ^{reg_wdata, ch_reload[1]};

endmodule

// File: rtl/pwmt_checker.sv
module pwmt_checker
    import pwmt_pkg::*;
#(
    parameter int CNT_W  = 16,
    parameter int ADDR_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] reg_addr,
    input logic              reg_wr,
    input logic [31:0]       reg_wdata,
    input ctrl_t             ctrl0,
    input ctrl_t             ctrl1,
    input logic [CNT_W-1:0]  load0,
    input logic [CNT_W-1:0]  cnt0,
    input logic              wrap0,
    input logic              wrap1,
    input logic              pwm_mode,
    input logic              pwm_out
);

    assert_out_gated_R5: assert property (@(posedge clk) disable iff (!rst_n)
        pwm_out |-> (ctrl0.pwm & ctrl1.pwm & ctrl0.ena & ctrl1.ena & ~ctrl0.load
                     & ~ctrl1.load & ~ctrl0.casc & ctrl0.arld & ctrl1.arld));

    assert_load_track_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl0.load |=> (cnt0 == $past(load0)));

    assert_down_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl0.ena & ~ctrl0.load & ctrl0.down & ~wrap0 & (cnt0 != '0))
        |=> (cnt0 == $past(cnt0) - 1'b1));

    assert_start_both_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr & reg_wdata[CB_ENALL] & ((reg_addr == ADDR_W'(0)) | (reg_addr == ADDR_W'(12))))
        |=> (ctrl0.ena & ctrl1.ena));

    assert_equal_low_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (pwm_mode & wrap0 & wrap1) |=> !pwm_out);

    assert_rise_at_wrap_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (pwm_mode & $past(pwm_mode) & $rose(pwm_out)) |-> $past(wrap0));

endmodule

bind pwm_dual_timer pwmt_checker #(
    .CNT_W (CNT_W),
    .ADDR_W(ADDR_W)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .reg_addr (reg_addr),
    .reg_wr   (reg_wr),
    .reg_wdata(reg_wdata),
    .ctrl0    (ch_ctrl[0]),
    .ctrl1    (ch_ctrl[1]),
    .load0    (ch_load[0]),
    .cnt0     (ch_cnt[0]),
    .wrap0    (ch_wrap[0]),
    .wrap1    (ch_wrap[1]),
    .pwm_mode (pwm_mode),
    .pwm_out  (pwm_out)
);

// File: tb/tb_pwm_dual_timer.sv
`timescale 1ns/1ps
module tb_pwm_dual_timer;

    localparam int CNT_W  = 4;
    localparam int ADDR_W = 8;
    localparam int MAXV   = (1 << CNT_W) - 1;

    localparam logic [31:0] B_DOWN  = 32'h002;
    localparam logic [31:0] B_LOAD  = 32'h020;
    localparam logic [31:0] B_ENA   = 32'h080;
    localparam logic [31:0] B_ARLD  = 32'h010;
    localparam logic [31:0] B_ENALL = 32'h400;
    localparam logic [31:0] B_CASC  = 32'h800;
    localparam logic [31:0] B_CAPT  = 32'h001;
    localparam logic [31:0] PWM_CFG = 32'h214;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [ADDR_W-1:0] reg_addr = '0;
    logic              reg_wr = 1'b0;
    logic [31:0]       reg_wdata = '0;
    logic [31:0]       reg_rdata;
    logic              pwm_out;

    int checks = 0;
    int errors = 0;

    pwm_dual_timer #(.CNT_W(CNT_W), .ADDR_W(ADDR_W)) dut (
        .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .pwm_out(pwm_out)
    );

    always #5 clk = ~clk;

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        reg_addr  = a;
        reg_wdata = d;
        reg_wr    = 1'b1;
        @(posedge clk);
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    function automatic int span(input bit dn, input int l);
        return dn ? l + 2 : MAXV - l + 2;
    endfunction

    function automatic bit exp_out(input int k, input int p, input int d);
        if (d > p) return 1'b1;
        if (d == p) return 1'b0;
        return (k % p) < d;
    endfunction

    // Ends at the first cycle of the first period (k = 0).
    task automatic start_pwm(input int l0, input int l1, input bit dn0, input bit dn1,
                             input logic [31:0] extra0, input logic [31:0] extra1);
        wr(8'h00, 32'h0);
        wr(8'h0C, 32'h0);
        wr(8'h04, 32'(l0));
        wr(8'h10, 32'(l1));
        wr(8'h00, B_LOAD | (dn0 ? B_DOWN : 32'h0));
        wr(8'h0C, B_LOAD | (dn1 ? B_DOWN : 32'h0));
        wr(8'h00, PWM_CFG | (dn0 ? B_DOWN : 32'h0) | extra0);
        wr(8'h0C, PWM_CFG | B_ENALL | (dn1 ? B_DOWN : 32'h0) | extra1);
    endtask

    task automatic run_wave(input int l0, input int l1, input bit dn0, input bit dn1, input string tag);
        int p, d, bad;
        p = span(dn0, l0);
        d = span(dn1, l1);
        bad = 0;
        start_pwm(l0, l1, dn0, dn1, 32'h0, 32'h0);
        for (int k = 0; k < 2 * p + 3; k++) begin
            if (pwm_out !== exp_out(k, p, d)) bad++;
            @(negedge clk);
        end
        chk(bad == 0, $sformatf("%s l0=%0d l1=%0d P=%0d D=%0d bad_cycles", tag, l0, l1, p, d),
            32'(bad), 32'h0);
    endtask

    task automatic expect_low(input int n, input string tag);
        int bad;
        bad = 0;
        for (int k = 0; k < n; k++) begin
            if (pwm_out !== 1'b0) bad++;
            @(negedge clk);
        end
        chk(bad == 0, tag, 32'(bad), 32'h0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0] v, w;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R11 reset state
        chk(pwm_out === 1'b0, "R11 out after reset", 32'(pwm_out), 32'h0);
        for (int a = 0; a < 6; a++) begin
            rd(8'(a * 4), v);
            chk(v === 32'h0, $sformatf("R11 reg %0d after reset", a), v, 32'h0);
        end

        // R1 and R4: control field storage, start-both bit
        wr(8'h00, 32'hFFFF_FFFF);
        rd(8'h00, v);
        chk(v === 32'h0000_0AB7, "R1 ctrl0 stored bits", v, 32'h0000_0AB7);
        rd(8'h0C, v);
        chk(v === B_ENA, "R4 ctrl1 enabled by start-both in ctrl0", v, B_ENA);
        wr(8'h04, 32'hFFFF_FFF3);
        rd(8'h04, v);
        chk(v === 32'h3, "R1 load0 keeps low bits", v, 32'h3);
        wr(8'h00, 32'h0);
        wr(8'h0C, 32'h0);
        wr(8'h08, 32'h9);
        rd(8'h08, v);
        chk(v === 32'h3, "R1 count0 write ignored", v, 32'h3);
        rd(8'h18, v);
        chk(v === 32'h0, "R1 unmapped reads zero", v, 32'h0);

        // R2 continuous load and hold
        wr(8'h04, 32'd9);
        wr(8'h00, B_LOAD | B_ENA | B_ARLD | B_DOWN);
        repeat (3) @(negedge clk);
        rd(8'h08, v);
        chk(v === 32'd9, "R2 count follows load", v, 32'd9);
        wr(8'h04, 32'd4);
        @(negedge clk);
        rd(8'h08, v);
        chk(v === 32'd4, "R2 count follows new load", v, 32'd4);
        repeat (3) @(negedge clk);
        rd(8'h08, v);
        chk(v === 32'd4, "R2 no counting while load set", v, 32'd4);

        // R3 down with auto-reload on channel 0
        wr(8'h00, 32'h0);
        wr(8'h04, 32'd5);
        wr(8'h00, B_LOAD | B_DOWN);
        wr(8'h00, B_ENA | B_ARLD | B_DOWN);
        rd(8'h08, v);
        chk(v === 32'd5, "R3 down k0", v, 32'd5);
        repeat (5) @(negedge clk);
        rd(8'h08, v);
        chk(v === 32'd0, "R3 down reaches zero", v, 32'd0);
        @(negedge clk);
        rd(8'h08, v);
        chk(v === 32'd0, "R3 down holds terminal one cycle", v, 32'd0);
        @(negedge clk);
        rd(8'h08, v);
        chk(v === 32'd5, "R3 down reload after L+2", v, 32'd5);
        rd(8'h00, v);
        chk(v === (B_ENA | B_ARLD | B_DOWN), "R10 direction bit kept", v, B_ENA | B_ARLD | B_DOWN);
        wr(8'h00, 32'h0);

        // R3 up one-shot on channel 1
        wr(8'h10, 32'd12);
        wr(8'h0C, B_LOAD);
        wr(8'h0C, B_ENA);
        repeat (3) @(negedge clk);
        rd(8'h14, v);
        chk(v === 32'd15, "R3 up reaches max", v, 32'd15);
        repeat (3) @(negedge clk);
        rd(8'h14, v);
        chk(v === 32'd15, "R3 one-shot stays at max", v, 32'd15);
        rd(8'h0C, v);
        chk(v === 32'h0, "R3 one-shot clears enable", v, 32'h0);

        // R4 both channels start at the same edge
        wr(8'h04, 32'd10);
        wr(8'h10, 32'd10);
        wr(8'h00, B_LOAD | B_DOWN);
        wr(8'h0C, B_LOAD | B_DOWN);
        wr(8'h00, B_DOWN);
        wr(8'h0C, B_DOWN | B_ENALL);
        repeat (4) @(negedge clk);
        rd(8'h08, v);
        rd(8'h14, w);
        chk(v === 32'd6 && w === 32'd6, "R4 counts aligned", {v[15:0], w[15:0]}, 32'h0006_0006);
        rd(8'h0C, v);
        chk(v === (B_DOWN | B_ENA), "R4 start-both reads zero", v, B_DOWN | B_ENA);

        // R6/R7/R8 exhaustive sweep, down counting
        for (int a = 0; a <= MAXV; a++) begin
            for (int b = 0; b <= MAXV; b++) begin
                int p, d;
                p = span(1'b1, a);
                d = span(1'b1, b);
                run_wave(a, b, 1'b1, 1'b1, (d < p) ? "R6" : ((d == p) ? "R7" : "R8"));
            end
        end

        // R10 sweep, up counting and mixed directions
        for (int a = 0; a <= MAXV; a++) begin
            for (int b = 0; b <= MAXV; b++) begin
                run_wave(a, b, 1'b0, 1'b0, "R10 up");
            end
        end
        run_wave(3, 13, 1'b1, 1'b0, "R10 mixed");
        run_wave(10, 6, 1'b0, 1'b1, "R10 mixed");

        // R9 load change in mid period
        begin
            int bad;
            bad = 0;
            start_pwm(14, 5, 1'b1, 1'b1, 32'h0, 32'h0);
            fork
                begin
                    for (int k = 0; k < 16 + 24; k++) begin
                        bit e;
                        e = (k < 16) ? exp_out(k, 16, 7) : exp_out(k - 16, 8, 4);
                        if (pwm_out !== e) bad++;
                        @(negedge clk);
                    end
                end
                begin
                    repeat (3) @(negedge clk);
                    wr(8'h04, 32'd6);
                    wr(8'h10, 32'd2);
                end
            join
            chk(bad == 0, "R9 mid-period load bad_cycles", 32'(bad), 32'h0);
        end

        // R5 gating
        wr(8'h00, 32'h0);
        wr(8'h0C, 32'h0);
        expect_low(40, "R5 both control words zero");
        start_pwm(8, 3, 1'b1, 1'b1, B_CASC, 32'h0);
        expect_low(40, "R5 chain bit blocks output");
        start_pwm(8, 3, 1'b1, 1'b1, 32'h0, B_LOAD);
        expect_low(40, "R5 load bit blocks output");
        start_pwm(8, 3, 1'b1, 1'b1, B_CAPT, 32'h0);
        expect_low(40, "R5 capture select blocks output");

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule